// File: doc/BRIEF.md
# Arithmetic Overflow Trap Capture Unit

This block sits beside the execute stage of a simple in-order core and turns an arithmetic overflow into a precise exception. Each cycle the execute stage presents a valid flag, the address of the instruction it is executing, an overflow flag from the ALU and a flag saying whether the operation is one of the trapping (signed-semantics) arithmetic forms. When all three flags are set, the unit does three things. It suppresses the register write of the faulting instruction in that same cycle. On the clock edge it saves the instruction's own address in the exception program counter. In the following cycle it issues a single-cycle fetch redirect to a fixed handler vector, so the trap behaves like an unplanned call.

Operations of the non-trapping (unsigned-named) arithmetic forms wrap silently. They never kill, redirect or touch the saved address. A control-register read port lets a move-from-control-register instruction copy the saved address into a general register. The port returns the saved address when its select matches the exception-PC index, and zero for any other select.

Top module: `ovf_trap_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the saved exception address to zero and drives `redirect_valid` low and `redirect_pc` to zero after that edge.
- R2: A trap is `ex_valid & ex_ovf & ex_trap_en`. On the clock edge of a trap cycle the saved exception address takes the value of `ex_pc` from that cycle.
- R3: In the cycle after a trap cycle, `redirect_valid` is 1 and `redirect_pc` equals the handler vector (default 0x80000180). In any cycle after a non-trap cycle, `redirect_valid` is 0 and `redirect_pc` is zero.
- R4: `wb_kill` is 1 combinationally during a trap cycle and 0 in every other cycle.
- R5: With `ex_trap_en` = 0 (non-trapping arithmetic form), an overflow causes no kill and no redirect, and leaves the saved address unchanged.
- R6: With `ex_valid` = 0, `ex_ovf` and `ex_trap_en` have no effect: no kill, no redirect, and the saved address is unchanged.
- R7: Without a trap, the saved exception address holds its value for any number of cycles.
- R8: With `rd_sel` equal to the exception-PC index (default 14), `rd_data` returns the saved address; any other select returns zero. With the default read latency of 0, the read is combinational, so a read in the cycle after a trap already sees the new address.
- R9: Two trap cycles back to back each capture their own address: the second overwrites the first, and `redirect_valid` stays 1 for both following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_ovf | input | 1 | ALU signed overflow for this instruction |
| ex_trap_en | input | 1 | 1 = trapping arithmetic form, 0 = wrapping form |
| ex_pc | input | ADDR_W | Address of the instruction in execute |
| wb_kill | output | 1 | Suppress this instruction's register write |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | ADDR_W | Redirect target (handler vector) |
| rd_sel | input | SEL_W | Control-register read select |
| rd_data | output | ADDR_W | Control-register read data |

## Verification
The bench targets the qualifier corners. An overflow from a wrapping operation, or one arriving with the valid flag low, must not fire; a design that got either wrong would kill a legal result and jump to the handler. It runs back-to-back traps, where a design that latched only the first trap or stretched the redirect would leave the wrong address saved. It also checks that the redirect drops after exactly one cycle, that the saved address survives long idle stretches and a non-matching read select, and that a reset in the middle of a run clears it. A misplaced register would show up as a kill one cycle late or as a read that lags the capture.

// File: rtl/ovf_trap_pkg.sv
package ovf_trap_pkg;
   localparam int unsigned DEF_ADDR_W = 32;
   localparam int unsigned DEF_SEL_W = 5;
   localparam logic [31:0] DEF_HANDLER_VEC = 32'h8000_0180;
   localparam int unsigned DEF_EPC_SEL = 14;

   typedef enum logic [1:0] {
      TRAP_NONE   = 2'b00,
      TRAP_MASKED = 2'b01,
      TRAP_FIRE   = 2'b10
   } trap_state_e;
endpackage

// File: rtl/ovf_trap_detect.sv
module ovf_trap_detect
   import ovf_trap_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        valid_i,
   input  logic        ovf_i,
   input  logic        trap_en_i,
   output trap_state_e state_o,
   output logic        fire_o
);
   always_comb begin
      if (valid_i && ovf_i)
         state_o = trap_en_i ? TRAP_FIRE : TRAP_MASKED;
      else
         state_o = TRAP_NONE;
   end

   assign fire_o = (state_o == TRAP_FIRE);

   // R5: a wrapping-form operation never fires
   a_r5_wrap_no_fire : assert property (@(posedge clk) disable iff (rst)
      !trap_en_i |-> !fire_o);
   // R6: an invalid slot never fires
   a_r6_invalid_no_fire : assert property (@(posedge clk) disable iff (rst)
      !valid_i |-> !fire_o);
endmodule

// File: rtl/ovf_epc_reg.sv
module ovf_epc_reg #(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] HANDLER_VEC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] epc_o,
   output logic              redir_v_o,
   output logic [ADDR_W-1:0] redir_pc_o
);
   logic [ADDR_W-1:0] epc_q;
   logic              redir_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         epc_q   <= '0;
         redir_q <= 1'b0;
      end else begin
         redir_q <= fire_i;
         if (fire_i)
            epc_q <= pc_i;
      end
   end

   assign epc_o      = epc_q;
   assign redir_v_o  = redir_q;
   assign redir_pc_o = redir_q ? HANDLER_VEC : '0;

   // R2: capture of the faulting address
   a_r2_epc_capture : assert property (@(posedge clk) disable iff (rst)
      fire_i |=> (epc_o == $past(pc_i)));
   // R3: redirect to the vector after a trap
   a_r3_redirect_vec : assert property (@(posedge clk) disable iff (rst)
      fire_i |=> (redir_v_o && redir_pc_o == HANDLER_VEC));
   // R3: no redirect after a quiet cycle
   a_r3_redirect_quiet : assert property (@(posedge clk) disable iff (rst)
      !fire_i |=> !redir_v_o);
   // R7: saved address holds without a trap
   a_r7_epc_hold : assert property (@(posedge clk) disable iff (rst)
      !fire_i |=> $stable(epc_o));
endmodule

// File: rtl/ovf_cp_read.sv
module ovf_cp_read #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SEL_W = 5,
   parameter int unsigned EPC_SEL = 14,
   parameter int unsigned RD_LAT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [ADDR_W-1:0] epc_i,
   output logic [ADDR_W-1:0] data_o
);
   localparam logic [SEL_W-1:0] SEL_MATCH = SEL_W'(EPC_SEL);

   logic [ADDR_W-1:0] mux_d;
   assign mux_d = (sel_i == SEL_MATCH) ? epc_i : '0;

   generate
      if (RD_LAT == 0) begin : g_comb
         assign data_o = mux_d;
         // R8: non-matching select reads zero
         a_r8_other_zero : assert property (@(posedge clk) disable iff (rst)
            (sel_i != SEL_MATCH) |-> (data_o == '0));
      end else begin : g_reg
         logic [ADDR_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (rst) data_q <= '0;
            else     data_q <= mux_d;
         end
         assign data_o = data_q;
         // R8: registered read returns last cycle's selection
         a_r8_reg_read : assert property (@(posedge clk) disable iff (rst)
            (sel_i == SEL_MATCH) |=> (data_o == $past(epc_i)));
      end
   endgenerate
endmodule

// File: rtl/ovf_trap_unit.sv
module ovf_trap_unit
   import ovf_trap_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned SEL_W = DEF_SEL_W,
   parameter logic [ADDR_W-1:0] HANDLER_VEC = ADDR_W'(DEF_HANDLER_VEC),
   parameter int unsigned EPC_SEL = DEF_EPC_SEL,
   parameter int unsigned RD_LAT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ex_valid,
   input  logic              ex_ovf,
   input  logic              ex_trap_en,
   input  logic [ADDR_W-1:0] ex_pc,
   output logic              wb_kill,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_pc,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [ADDR_W-1:0] rd_data
);
   localparam int unsigned SEL_SPACE = 1 << SEL_W;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ovf_trap_unit: ADDR_W out of range");
      end
      if (EPC_SEL >= SEL_SPACE) begin : g_bad_sel
         $error("ovf_trap_unit: EPC_SEL does not fit in SEL_W");
      end
      if (RD_LAT > 1) begin : g_bad_lat
         $error("ovf_trap_unit: RD_LAT must be 0 or 1");
      end
      if (HANDLER_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("ovf_trap_unit: handler vector must be word aligned");
      end
   endgenerate

   trap_state_e       trap_state;
   logic              fire;
   logic [ADDR_W-1:0] epc;

   ovf_trap_detect u_detect (
      .clk       (clk),
      .rst       (rst),
      .valid_i   (ex_valid),
      .ovf_i     (ex_ovf),
      .trap_en_i (ex_trap_en),
      .state_o   (trap_state),
      .fire_o    (fire)
   );

   ovf_epc_reg #(
      .ADDR_W      (ADDR_W),
      .HANDLER_VEC (HANDLER_VEC)
   ) u_epc (
      .clk        (clk),
      .rst        (rst),
      .fire_i     (fire),
      .pc_i       (ex_pc),
      .epc_o      (epc),
      .redir_v_o  (redirect_valid),
      .redir_pc_o (redirect_pc)
   );

   ovf_cp_read #(
      .ADDR_W  (ADDR_W),
      .SEL_W   (SEL_W),
      .EPC_SEL (EPC_SEL),
      .RD_LAT  (RD_LAT)
   ) u_read (
      .clk    (clk),
      .rst    (rst),
      .sel_i  (rd_sel),
      .epc_i  (epc),
      .data_o (rd_data)
   );

   assign wb_kill = fire;

   // R4: kill only when the ALU reported overflow on a valid trapping op
   a_r4_kill_cause : assert property (@(posedge clk) disable iff (rst)
      wb_kill |-> (ex_valid && ex_ovf && ex_trap_en));
   // R4: a kill always leads to a redirect next cycle
   a_r4_kill_redirect : assert property (@(posedge clk) disable iff (rst)
      wb_kill |=> redirect_valid);
   // R9: back-to-back traps keep the redirect raised
   a_r9_back_to_back : assert property (@(posedge clk) disable iff (rst)
      (wb_kill && $past(wb_kill)) |-> redirect_valid);
   // R5: masked overflow never kills
   a_r5_masked_no_kill : assert property (@(posedge clk) disable iff (rst)
      (trap_state == TRAP_MASKED) |-> !wb_kill);
endmodule

// File: tb/ovf_trap_unit_tb.sv
`timescale 1ns/1ps
module ovf_trap_unit_tb;
   localparam logic [31:0] VEC = 32'h8000_0180;
   localparam logic [4:0]  EPC_IDX = 5'd14;
   localparam int NVEC = 8;
   // fields: [34] valid, [33] ovf, [32] trap_en, [31:0] pc
   localparam logic [34:0] VTAB [NVEC] = '{
      {3'b111, 32'h0040_0010},
      {3'b101, 32'h0040_0014},
      {3'b110, 32'h0040_0018},
      {3'b011, 32'h0040_001C},
      {3'b111, 32'h0040_0020},
      {3'b111, 32'hFFFF_FFFC},
      {3'b000, 32'h1234_5678},
      {3'b111, 32'h8000_0180}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        ex_valid, ex_ovf, ex_trap_en;
   logic [31:0] ex_pc;
   logic        wb_kill, redirect_valid;
   logic [31:0] redirect_pc, rd_data;
   logic [4:0]  rd_sel;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   logic [31:0] model_epc;

   always #2.5 clk = ~clk;

   ovf_trap_unit u_dut (
      .clk            (clk),
      .rst            (rst),
      .ex_valid       (ex_valid),
      .ex_ovf         (ex_ovf),
      .ex_trap_en     (ex_trap_en),
      .ex_pc          (ex_pc),
      .wb_kill        (wb_kill),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .rd_sel         (rd_sel),
      .rd_data        (rd_data)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic o, input logic e, input logic [31:0] pc);
      @(negedge clk);
      ex_valid = v; ex_ovf = o; ex_trap_en = e; ex_pc = pc;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; ex_valid = 0; ex_ovf = 0; ex_trap_en = 0; ex_pc = '0;
      rd_sel = EPC_IDX; model_epc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      chk(rd_data, 32'h0, "R1 epc after reset");
      chk({31'b0, redirect_valid}, 32'h0, "R1 redirect after reset");
      chk({31'b0, wb_kill}, 32'h0, "R1 kill after reset");

      for (int i = 0; i < NVEC; i++) begin
         logic v, o, e, exp_trap;
         logic [31:0] pc;
         string tag;
         {v, o, e, pc} = VTAB[i];
         exp_trap = v & o & e;
         tag = !v ? "R6" : (o && !e) ? "R5" : (i == 5) ? "R9" : exp_trap ? "R2" : "R7";
         drive(v, o, e, pc);
         #1;
         chk({31'b0, wb_kill}, {31'b0, exp_trap}, {tag, "/R4 kill"});
         if (exp_trap) model_epc = pc;
         @(posedge clk); #1;
         chk({31'b0, redirect_valid}, {31'b0, exp_trap}, {tag, "/R3 redirect valid"});
         chk(redirect_pc, exp_trap ? VEC : 32'h0, {tag, "/R3 redirect pc"});
         chk(rd_data, model_epc, {tag, "/R8 epc read"});
      end

      // R3: pulse ends after one cycle
      drive(0, 0, 0, 32'h0);
      drive(1, 1, 1, 32'h0000_0A00); model_epc = 32'h0000_0A00;
      drive(0, 0, 0, 32'h0);
      #1;
      chk({31'b0, redirect_valid}, 32'h1, "R3 pulse high");
      @(posedge clk); #1;
      chk({31'b0, redirect_valid}, 32'h0, "R3 pulse drops");
      chk(redirect_pc, 32'h0, "R3 pc zero when idle");

      // R7: long hold with overflow noise on wrapping ops
      for (int k = 0; k < 40; k++) drive(1, 1, 0, 32'hDEAD_0000 + k);
      #1;
      chk(rd_data, model_epc, "R7 hold after idle");
      chk(rd_data, model_epc, "R5 wrapping overflow left epc");

      // R8: other selects read zero
      @(negedge clk); rd_sel = 5'd13; #1;
      chk(rd_data, 32'h0, "R8 sel 13 zero");
      rd_sel = 5'd15; #1;
      chk(rd_data, 32'h0, "R8 sel 15 zero");
      rd_sel = EPC_IDX; #1;
      chk(rd_data, model_epc, "R8 sel 14 epc");

      // R1: reset in the middle of a run, with a trap present
      drive(1, 1, 1, 32'h0000_4444);
      rst = 1'b1;
      @(posedge clk); #1;
      chk(rd_data, 32'h0, "R1 mid-run reset clears epc");
      chk({31'b0, redirect_valid}, 32'h0, "R1 mid-run reset no redirect");
      drive(0, 0, 0, 32'h0); rst = 1'b0;
      @(posedge clk); #1;
      chk(rd_data, 32'h0, "R1 epc stays zero");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule